// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter built as a chain of narrow stages. The count can be preset from a parallel data word and cleared at any moment by an active-low clear. Each stage has two count enables. The shared enable `en_par` only gates counting. The carry enable gates counting and also gates the stage's terminal-count flag.

Inside the wrapper, each stage's terminal count feeds the carry enable of the stage above it. `en_par` goes to all stages in common. The chain therefore counts as one wide binary counter, and a higher stage steps only in the cycle where every stage below it wraps. The terminal count of the last stage is the block output. It responds combinationally to `en_carry`, so a further counter can be chained to this one from outside.

The clear takes effect asynchronously. It is released through a synchronizer inside the block, so the counter stays at zero for two rising edges after `clr_n` returns high.

Top module: `chain_counter`

## Requirements
- R1: While `clr_n` is low, `count` is zero and `tc` is low at once, with no clock edge needed, whatever the other inputs are.
- R2: After `clr_n` rises, the first two rising edges leave `count` at zero even when a load or an increment is requested. The third edge is the first that acts.
- R3: A rising edge with `load_n` low copies `din` into `count`, whatever the levels of `en_par` and `en_carry`.
- R4: With `load_n` high and both `en_par` and `en_carry` high, each rising edge adds one to the whole `count`. The value is a single binary number, with stage 0 in bits [3:0].
- R5: With `load_n` high and either enable low, `count` keeps its value across the edge.
- R6: `tc` is high exactly when `en_carry` is high and every bit of `count` is one. It follows `en_carry` without a clock edge.
- R7: An enabled increment from all ones gives zero. After a load of 12, the low stage reads 13, 14, 15, 0, 1, 2 and then holds when counting is inhibited.
- R8: A higher stage advances only on the edge where all lower stages wrap. For example, 0x0FF steps to 0x100, and 0x0FE steps to 0x0FF with the upper stage untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear, asserted asynchronously |
| load_n | input | 1 | Active-low synchronous parallel load |
| din | input | 12 | Parallel preset word (STAGE_W*N_STAGES) |
| en_par | input | 1 | Count enable shared by all stages |
| en_carry | input | 1 | Carry enable into stage 0; also gates `tc` |
| count | output | 12 | Concatenated count of all stages |
| tc | output | 1 | Terminal count of the last stage |

## Verification
A wrong carry between stages shows up at `count` on the edge where a lower stage wraps. The upper bits either step too early or fail to step, so the bench compares every cycle against a wide integer model. A stuck or mis-gated enable shows up after a single edge as a held value or a spurious step. A fault in the terminal-count path can be seen without any clock: moving `en_carry` while the count is all ones must change `tc` at once. A fault in the release synchronizer shows up as a load taking effect one or two edges too early after clear.

// File: rtl/chain_counter_pkg.sv
package chain_counter_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2
  } stage_op_e;

  // A load wins over both enables; counting needs both enables high.
  function automatic stage_op_e pick_op(input logic load_n,
                                        input logic cep,
                                        input logic cet);
    if (!load_n)         return OP_LOAD;
    else if (cep && cet) return OP_INC;
    else                 return OP_HOLD;
  endfunction

endpackage

// File: rtl/clear_sync.sv
module clear_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic live
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], 1'b1};
  end

  assign live = shreg[STAGES-1];
endmodule

// File: rtl/count_stage.sv
module count_stage
  import chain_counter_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         live,
  input  logic         load_n,
  input  logic [W-1:0] d,
  input  logic         cep,
  input  logic         cet,
  output logic [W-1:0] q,
  output logic         tc
);
  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] bump(input logic [W-1:0] v);
    return v + ONE;
  endfunction

  function automatic logic at_top(input logic [W-1:0] v);
    return &v;
  endfunction

  stage_op_e op;
  assign op = pick_op(load_n, cep, cet);

  always_ff @(posedge clk or negedge live) begin
    if (!live) q <= '0;
    else begin
      case (op)
        OP_LOAD: q <= d;
        OP_INC:  q <= bump(q);
        default: q <= q;
      endcase
    end
  end

  assign tc = cet & at_top(q);
endmodule

// File: rtl/chain_counter.sv
module chain_counter #(
  parameter int STAGE_W     = 4,
  parameter int N_STAGES    = 3,
  parameter int SYNC_STAGES = 2,
  localparam int TOTAL_W    = STAGE_W * N_STAGES
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic               load_n,
  input  logic [TOTAL_W-1:0] din,
  input  logic               en_par,
  input  logic               en_carry,
  output logic [TOTAL_W-1:0] count,
  output logic               tc
);
  logic              live;
  logic [N_STAGES:0] carry_chain;

  clear_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .clr_n(clr_n),
    .live (live)
  );

  assign carry_chain[0] = en_carry;

  for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
    count_stage #(.W(STAGE_W)) u_stage (
      .clk   (clk),
      .live  (live),
      .load_n(load_n),
      .d     (din[i*STAGE_W +: STAGE_W]),
      .cep   (en_par),
      .cet   (carry_chain[i]),
      .q     (count[i*STAGE_W +: STAGE_W]),
      .tc    (carry_chain[i+1])
    );
  end

  assign tc = carry_chain[N_STAGES];
endmodule

// File: rtl/chain_counter_chk.sv
module chain_counter_chk #(
  parameter int TOTAL_W = 12
) (
  input logic               clk,
  input logic               clr_n,
  input logic               live,
  input logic               load_n,
  input logic [TOTAL_W-1:0] din,
  input logic               en_par,
  input logic               en_carry,
  input logic [TOTAL_W-1:0] count,
  input logic               tc
);
  localparam logic [TOTAL_W-1:0] ONE = TOTAL_W'(1);

  assert_clear_zero_R1: assert property (@(posedge clk)
    !clr_n |-> (count == '0 && !tc));

  assert_release_hold_R2: assert property (@(posedge clk) disable iff (!clr_n)
    !live |=> count == '0);

  assert_load_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (live && !load_n) |=> count == $past(din));

  assert_increment_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (live && load_n && en_par && en_carry) |=> count == $past(count) + ONE);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (live && load_n && !(en_par && en_carry)) |=> $stable(count));

  assert_tc_R6: assert property (@(posedge clk) disable iff (!clr_n)
    tc == (en_carry && (&count)));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!clr_n)
    (live && load_n && en_par && en_carry && (&count)) |=> count == '0);
endmodule

bind chain_counter chain_counter_chk #(.TOTAL_W(TOTAL_W)) u_chk (
  .clk     (clk),
  .clr_n   (clr_n),
  .live    (live),
  .load_n  (load_n),
  .din     (din),
  .en_par  (en_par),
  .en_carry(en_carry),
  .count   (count),
  .tc      (tc)
);

// File: tb/tb_chain_counter.sv
module tb_chain_counter;
  localparam int SW = 4;
  localparam int NS = 3;
  localparam int TW = SW * NS;
  localparam logic [TW-1:0] ALL1 = '1;

  logic clk = 1'b0;
  logic clr_n = 1'b1;
  logic load_n = 1'b1;
  logic en_par = 1'b0;
  logic en_carry = 1'b0;
  logic [TW-1:0] din = '0;
  wire  [TW-1:0] count;
  wire           tc;

  int n_vec = 0;
  int n_bad = 0;
  logic [TW-1:0] mdl = '0;
  int rel = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  chain_counter #(.STAGE_W(SW), .N_STAGES(NS)) dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
    .en_par(en_par), .en_carry(en_carry), .count(count), .tc(tc)
  );

  task automatic note(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One edge: update the model from the requirements, then compare.
  task automatic tick(input string tag);
    @(posedge clk);
    if (clr_n) begin
      if (rel < 2)              rel++;
      else if (!load_n)         mdl = din;
      else if (en_par && en_carry) mdl = mdl + 1'b1;
    end else begin
      mdl = '0;
    end
    #1;
    note(tag, count, mdl);
    note({tag, " tc"}, TW'(tc), TW'(en_carry && clr_n && (mdl == ALL1)));
    @(negedge clk);
  endtask

  task automatic do_load(input logic [TW-1:0] v, input logic p, input logic c, input string tag);
    load_n = 1'b0; din = v; en_par = p; en_carry = c;
    tick(tag);
    load_n = 1'b1;
  endtask

  task automatic t_reset;
    en_carry = 1'b1;
    #1 clr_n = 1'b0;
    #1 note("R1 clear at start", count, '0);
    note("R1 tc during clear", TW'(tc), '0);
    tick("R1");
    @(negedge clk);
    clr_n = 1'b1; rel = 0;
    load_n = 1'b0; din = 12'h5A5; en_par = 1'b1;
    tick("R2 first edge after release");
    tick("R2 second edge after release");
    tick("R3 first acting edge");
    note("R3 load after release", count, 12'h5A5);
    load_n = 1'b1;
  endtask

  task automatic t_load_disabled;
    do_load(12'h3C7, 1'b0, 1'b0, "R3 load with enables low");
    note("R3 value", count, 12'h3C7);
    do_load(12'h812, 1'b1, 1'b0, "R3 load with carry low");
    note("R3 value", count, 12'h812);
    do_load(12'h0A0, 1'b0, 1'b1, "R3 load with par low");
    note("R3 value", count, 12'h0A0);
    en_par = 1'b0; en_carry = 1'b1; tick("R5 par low");
    en_par = 1'b1; en_carry = 1'b0; tick("R5 carry low");
    en_par = 1'b0; en_carry = 1'b0; tick("R5 both low");
    note("R5 held", count, 12'h0A0);
  endtask

  task automatic t_sequence;
    logic [SW-1:0] exp_lo [6] = '{4'd13, 4'd14, 4'd15, 4'd0, 4'd1, 4'd2};
    do_load(12'h00C, 1'b1, 1'b1, "R7 preset twelve");
    for (int i = 0; i < 6; i++) begin
      tick("R4 count");
      note("R7 low stage sequence", TW'(count[SW-1:0]), TW'(exp_lo[i]));
    end
    en_par = 1'b0;
    tick("R5 inhibit");
    note("R7 inhibit holds", TW'(count[SW-1:0]), TW'(4'd2));
  endtask

  task automatic t_tc_comb;
    do_load(ALL1, 1'b0, 1'b0, "R6 load all ones");
    #1 note("R6 tc low with carry low", TW'(tc), '0);
    en_carry = 1'b1;
    #1 note("R6 tc follows carry without edge", TW'(tc), TW'(1'b1));
    en_carry = 1'b0;
    #1 note("R6 tc drops with carry", TW'(tc), '0);
    @(negedge clk);
    do_load(12'hFFE, 1'b0, 1'b1, "R6 one below top");
    #1 note("R6 tc low below top", TW'(tc), '0);
    @(negedge clk);
  endtask

  task automatic t_cascade;
    do_load(12'h0FE, 1'b1, 1'b1, "R8 preset");
    tick("R8 no upper step");
    note("R8 upper untouched", count, 12'h0FF);
    tick("R8 wrap into upper stage");
    note("R8 upper stepped", count, 12'h100);
    do_load(12'h00F, 1'b1, 1'b1, "R8 preset 0x00F");
    tick("R8 middle stage step");
    note("R8 0x010", count, 12'h010);
  endtask

  task automatic t_full_wrap;
    do_load(12'hFFD, 1'b1, 1'b1, "R7 preset near top");
    for (int i = 0; i < 4; i++) tick("R7 wrap region");
    note("R7 wrap to one", count, 12'h001);
    do_load('0, 1'b1, 1'b1, "R4 preset zero");
    for (int i = 0; i < (1 << TW); i++) tick("R4 full chain");
    note("R7 full chain wrap", count, '0);
  endtask

  task automatic t_clear_mid;
    do_load(12'h123, 1'b1, 1'b1, "R1 preset");
    tick("R4 count before clear");
    #1 clr_n = 1'b0;
    #0.5 note("R1 clear mid-cycle", count, '0);
    note("R1 tc mid-cycle", TW'(tc), '0);
    mdl = '0;
    tick("R1 held in clear");
    clr_n = 1'b1; rel = 0;
    tick("R2 edge one");
    tick("R2 edge two");
    tick("R4 first count");
    note("R2 counting resumes", count, 12'h001);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_load_disabled();
    t_sequence();
    t_tc_comb();
    t_cascade();
    t_full_wrap();
    t_clear_mid();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule